// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block walks a linked list of frame descriptors for a set of display DMA channels. On each frame-start pulse it visits the channels one after another in ascending order. For each enabled channel it reads a four-word descriptor from memory through a simple word-read port, one word at a time. The four words are the address of the next descriptor, the frame source address, a frame identifier and a command word. The fetched values drive per-channel outputs that a pixel mover downstream uses. The command word is also split into a transfer length and three flags.

Software can redirect one fetch per channel through a branch register, and may ask for a one-cycle branch event when the redirect is used. Before a descriptor is read, its address is checked against two memory windows. After a channel's slot, an enabled channel whose source is zero or lies outside both windows produces a bus-error pulse that carries its channel number.

The controller is a five-state machine. ST_IDLE goes to ST_PICK on frame_start. ST_PICK clears the channel's source and resolves the fetch address. From ST_PICK it goes to ST_STEP when the channel is disabled, to ST_READ when the descriptor fits a window, and to ST_JUDGE otherwise. ST_READ goes to ST_JUDGE after the fourth word is acknowledged. ST_JUDGE raises the bus error and applies any deferred pointer write, then goes to ST_STEP. ST_STEP goes back to ST_PICK for the next channel, or to ST_IDLE with a done pulse after the last channel.

Top module: `fdesc_fetcher`

## Requirements
- R1: A frame_start pulse while idle raises busy on the next cycle. A frame_start while busy is ignored. Each pass ends with exactly one single-cycle done pulse, and busy is low in that cycle.
- R2: Channels are visited in ascending order. An enabled channel's descriptor at address A is read as words A, A+4, A+8 and A+12, with one request outstanding at a time. The request address is held until mem_ack. The words become the next pointer (low 4 bits forced to zero), the source, the ID and the command.
- R3: Each channel's source output is cleared at the start of its slot. A disabled channel makes no memory read, keeps source zero and raises no bus error. Its ID and command keep their previous values.
- R4: The channel enables are: channel 0 is main_en; channel 1 is ovl1_en OR dual_scan; channels 2 to 4 are ovl2_en; channel 5 is cursor_en; any further channel is never enabled.
- R5: If bit 0 of a channel's branch register is set, the fetch uses the branch register bits 31:4 with four zero bits appended, and hardware clears bit 0. If bit 1 is also set, bit ch of bs_evt pulses for one cycle.
- R6: Without a pending branch, the fetch address is the channel's stored next pointer. That pointer is the value fetched in the previous pass or the value last written by software.
- R7: A descriptor is read only if, for one window, A >= base and A+16 <= base+size. Otherwise no request is issued and the source stays zero.
- R8: An enabled channel whose source is zero, or lies outside both windows (base <= S < base+size fails for both), gets a one-cycle ber_evt with ber_ch equal to its channel number.
- R9: ch_len is command bits 20:2 with two zero bits appended. ch_eof_irq is command bit 21, ch_sof_irq is bit 22 and ch_pal is bit 26.
- R10: The register block for channel ch sits at 0x200+16*ch. Offset +0x0 is the next pointer; it is writable and its low 4 bits are forced to zero. Offsets +0x4 (source), +0x8 (ID) and +0xC (command) are read-only. Reads of any unmapped or non-word-aligned address return zero.
- R11: The branch register for channel ch sits at 0x100+4*ch. A write keeps bits 31:4 and 1:0 and clears bits 3:2.
- R12: A next-pointer write to a channel during that channel's own ST_PICK or ST_READ is deferred. After the slot, the pointer holds the written value, not the fetched one.
- R13: After reset the block is idle, every output is zero, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts one pass over all channels |
| main_en | input | 1 | Main plane enable |
| dual_scan | input | 1 | Dual-scan mode, also enables channel 1 |
| ovl1_en | input | 1 | Overlay 1 enable |
| ovl2_en | input | 1 | Overlay 2 enable |
| cursor_en | input | 1 | Cursor enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word read address |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | Pass finished pulse |
| ch_src | output | NCH x 32 | Per-channel source address |
| ch_id | output | NCH x 32 | Per-channel frame ID |
| ch_cmd | output | NCH x 32 | Per-channel raw command |
| ch_len | output | NCH x 21 | Per-channel transfer length in bytes |
| ch_eof_irq | output | NCH | End-of-frame interrupt request flag |
| ch_sof_irq | output | NCH | Start-of-frame interrupt request flag |
| ch_pal | output | NCH | Palette-load flag |
| bs_evt | output | NCH | Branch-taken event pulses |
| ber_evt | output | 1 | Bus error pulse |
| ber_ch | output | 3 | Channel number of the bus error |

## Verification
A wrong channel index or word counter shows up on mem_addr within the same pass, as a request out of ascending order or at a wrong offset. It also shows one cycle later on ch_src, ch_id and ch_cmd once done is seen. A stale branch bit or next pointer shows up in the following pass, as a refetch from the wrong address and a mismatched pointer readback. A missed bus-error or branch event appears as an absent pulse within two cycles of the channel's slot. The bench sweeps the channel enables, branch combinations and window edges, and compares every channel's outputs and register readbacks after each pass.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_READ,
        ST_JUDGE,
        ST_STEP
    } fdf_state_e;

    localparam int CMD_LEN_LO = 2;
    localparam int CMD_LEN_HI = 20;
    localparam int CMD_EOF    = 21;
    localparam int CMD_SOF    = 22;
    localparam int CMD_PAL    = 26;

    localparam int BR_TAKE   = 0;
    localparam int BR_NOTIFY = 1;
    localparam logic [WORD_W-1:0] BR_KEEP = 32'hFFFF_FFF3;

    localparam logic [3:0] PAGE_BRANCH = 4'h1;
    localparam logic [3:0] PAGE_CHAN   = 4'h2;
endpackage

// File: rtl/fdf_chan_en.sv
module fdf_chan_en #(
    parameter int NCH = 7
) (
    input  logic           main_en,
    input  logic           dual_scan,
    input  logic           ovl1_en,
    input  logic           ovl2_en,
    input  logic           cursor_en,
    output logic [NCH-1:0] ch_en
);
    for (genvar i = 0; i < NCH; i++) begin : g_en
        if (i == 0) begin : g_main
            assign ch_en[i] = main_en;
        end else if (i == 1) begin : g_ovl1
            assign ch_en[i] = ovl1_en | dual_scan;
        end else if (i <= 4) begin : g_ovl2
            assign ch_en[i] = ovl2_en;
        end else if (i == 5) begin : g_cur
            assign ch_en[i] = cursor_en;
        end else begin : g_off
            assign ch_en[i] = 1'b0;
        end
    end
endmodule

// File: rtl/fdf_addr_win.sv
module fdf_addr_win #(
    parameter logic [31:0] W0_BASE = 32'h1000_0000,
    parameter logic [31:0] W0_SIZE = 32'h0000_1000,
    parameter logic [31:0] W1_BASE = 32'h2000_0000,
    parameter logic [31:0] W1_SIZE = 32'h0000_0100,
    parameter int          SPAN    = 16
) (
    input  logic [31:0] addr,
    output logic        ok
);
    localparam logic [32:0] LO0 = {1'b0, W0_BASE};
    localparam logic [32:0] HI0 = {1'b0, W0_BASE} + {1'b0, W0_SIZE};
    localparam logic [32:0] LO1 = {1'b0, W1_BASE};
    localparam logic [32:0] HI1 = {1'b0, W1_BASE} + {1'b0, W1_SIZE};

    logic [32:0] a_lo, a_hi;
    assign a_lo = {1'b0, addr};
    assign a_hi = {1'b0, addr} + 33'(SPAN);
    assign ok   = ((a_lo >= LO0) && (a_hi <= HI0)) || ((a_lo >= LO1) && (a_hi <= HI1));
endmodule

// File: rtl/fdesc_fetcher.sv
module fdesc_fetcher
    import fdf_pkg::*;
#(
    parameter int          NCH     = 7,
    parameter logic [31:0] W0_BASE = 32'h1000_0000,
    parameter logic [31:0] W0_SIZE = 32'h0000_1000,
    parameter logic [31:0] W1_BASE = 32'h2000_0000,
    parameter logic [31:0] W1_SIZE = 32'h0000_0100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    main_en,
    input  logic                    dual_scan,
    input  logic                    ovl1_en,
    input  logic                    ovl2_en,
    input  logic                    cursor_en,
    input  logic                    reg_we,
    input  logic [11:0]             reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    mem_req,
    output logic [31:0]             mem_addr,
    input  logic                    mem_ack,
    input  logic [31:0]             mem_rdata,
    output logic                    busy,
    output logic                    done,
    output logic [NCH-1:0][31:0]    ch_src,
    output logic [NCH-1:0][31:0]    ch_id,
    output logic [NCH-1:0][31:0]    ch_cmd,
    output logic [NCH-1:0][20:0]    ch_len,
    output logic [NCH-1:0]          ch_eof_irq,
    output logic [NCH-1:0]          ch_sof_irq,
    output logic [NCH-1:0]          ch_pal,
    output logic [NCH-1:0]          bs_evt,
    output logic                    ber_evt,
    output logic [2:0]              ber_ch
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

    fdf_state_e state_q, state_d;
    logic [CHW-1:0]              ch_q;
    logic [1:0]                  widx_q;
    logic [31:0]                 base_q;
    logic [NCH-1:0][31:0]        nxt_q, src_q, id_q, cmd_q, br_q;
    logic                        pend_v_q;
    logic [31:0]                 pend_q;
    logic [NCH-1:0]              ch_en;
    logic [31:0]                 pick_addr;
    logic                        desc_ok, src_ok;

    fdf_chan_en #(.NCH(NCH)) u_en (
        .main_en(main_en), .dual_scan(dual_scan), .ovl1_en(ovl1_en),
        .ovl2_en(ovl2_en), .cursor_en(cursor_en), .ch_en(ch_en)
    );

    assign pick_addr = br_q[ch_q][BR_TAKE] ? {br_q[ch_q][31:4], 4'h0} : nxt_q[ch_q];

    fdf_addr_win #(.W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE), .W1_BASE(W1_BASE),
                   .W1_SIZE(W1_SIZE), .SPAN(16)) u_desc_win (
        .addr(pick_addr), .ok(desc_ok)
    );
    fdf_addr_win #(.W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE), .W1_BASE(W1_BASE),
                   .W1_SIZE(W1_SIZE), .SPAN(1)) u_src_win (
        .addr(src_q[ch_q]), .ok(src_ok)
    );

    // register decode, shared by reads and writes
    logic           sel_chan, sel_br;
    logic [CHW-1:0] ach, bch;
    assign sel_chan = (reg_addr[11:8] == PAGE_CHAN) && (int'(reg_addr[7:4]) < NCH)
                      && (reg_addr[1:0] == 2'b00);
    assign sel_br   = (reg_addr[11:8] == PAGE_BRANCH) && (int'(reg_addr[7:2]) < NCH)
                      && (reg_addr[1:0] == 2'b00);
    assign ach = reg_addr[4 +: CHW];
    assign bch = reg_addr[2 +: CHW];

    always_comb begin
        reg_rdata = '0;
        if (sel_chan) begin
            unique case (reg_addr[3:2])
                2'd0: reg_rdata = nxt_q[ach];
                2'd1: reg_rdata = src_q[ach];
                2'd2: reg_rdata = id_q[ach];
                default: reg_rdata = cmd_q[ach];
            endcase
        end else if (sel_br) begin
            reg_rdata = br_q[bch];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_start) state_d = ST_PICK;
            ST_PICK:  if (!ch_en[ch_q]) state_d = ST_STEP;
                      else if (desc_ok) state_d = ST_READ;
                      else              state_d = ST_JUDGE;
            ST_READ:  if (mem_ack && (widx_q == 2'd3)) state_d = ST_JUDGE;
            ST_JUDGE: state_d = ST_STEP;
            ST_STEP:  state_d = (ch_q == LAST_CH) ? ST_IDLE : ST_PICK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    logic own_slot;
    assign own_slot = (ach == ch_q) && ch_en[ch_q] &&
                      ((state_q == ST_PICK) || (state_q == ST_READ));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0; widx_q <= '0; base_q <= '0;
            nxt_q <= '0; src_q <= '0; id_q <= '0; cmd_q <= '0; br_q <= '0;
            pend_v_q <= 1'b0; pend_q <= '0;
            bs_evt <= '0; ber_evt <= 1'b0; ber_ch <= '0; done <= 1'b0;
        end else begin
            bs_evt  <= '0;
            ber_evt <= 1'b0;
            done    <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (frame_start) ch_q <= '0;
                ST_PICK: begin
                    src_q[ch_q] <= '0;
                    widx_q      <= 2'd0;
                    base_q      <= pick_addr;
                    if (ch_en[ch_q] && br_q[ch_q][BR_TAKE]) begin
                        br_q[ch_q][BR_TAKE] <= 1'b0;
                        if (br_q[ch_q][BR_NOTIFY]) bs_evt[ch_q] <= 1'b1;
                    end
                end
                ST_READ: if (mem_ack) begin
                    widx_q <= widx_q + 2'd1;
                    unique case (widx_q)
                        2'd0: nxt_q[ch_q] <= {mem_rdata[31:4], 4'h0};
                        2'd1: src_q[ch_q] <= mem_rdata;
                        2'd2: id_q[ch_q]  <= mem_rdata;
                        default: cmd_q[ch_q] <= mem_rdata;
                    endcase
                end
                ST_JUDGE: begin
                    if ((src_q[ch_q] == '0) || !src_ok) begin
                        ber_evt <= 1'b1;
                        ber_ch  <= 3'(ch_q);
                    end
                    if (pend_v_q) nxt_q[ch_q] <= pend_q;
                    pend_v_q <= 1'b0;
                end
                ST_STEP: begin
                    if (ch_q == LAST_CH) done <= 1'b1;
                    else                 ch_q <= ch_q + 1'b1;
                end
                default: ;
            endcase
            if (reg_we && sel_chan && (reg_addr[3:2] == 2'd0)) begin
                if (own_slot) begin
                    pend_v_q <= 1'b1;
                    pend_q   <= {reg_wdata[31:4], 4'h0};
                end else begin
                    nxt_q[ach] <= {reg_wdata[31:4], 4'h0};
                end
            end
            if (reg_we && sel_br) br_q[bch] <= reg_wdata & BR_KEEP;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign mem_req  = (state_q == ST_READ);
    assign mem_addr = base_q + 32'({widx_q, 2'b00});
    assign ch_src   = src_q;
    assign ch_id    = id_q;
    assign ch_cmd   = cmd_q;

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign ch_len[g]     = {cmd_q[g][CMD_LEN_HI:CMD_LEN_LO], 2'b00};
        assign ch_eof_irq[g] = cmd_q[g][CMD_EOF];
        assign ch_sof_irq[g] = cmd_q[g][CMD_SOF];
        assign ch_pal[g]     = cmd_q[g][CMD_PAL];
    end

    // assertions
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && frame_start) |=> busy);
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    p_req_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    p_bs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bs_evt));
    p_req_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((({1'b0, mem_addr} >= {1'b0, W0_BASE}) &&
                      ({1'b0, mem_addr} < ({1'b0, W0_BASE} + {1'b0, W0_SIZE}))) ||
                     (({1'b0, mem_addr} >= {1'b0, W1_BASE}) &&
                      ({1'b0, mem_addr} < ({1'b0, W1_BASE} + {1'b0, W1_SIZE})))));
    p_ber_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ber_evt |-> (int'(ber_ch) < NCH));
endmodule

// File: tb/sim_fdesc_fetcher.sv
module sim_fdesc_fetcher;
    localparam int NCH = 7;
    localparam logic [32:0] W0B = 33'h1000_0000, W0S = 33'h0000_1000;
    localparam logic [32:0] W1B = 33'h2000_0000, W1S = 33'h0000_0100;

    logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
    logic main_en = 0, dual_scan = 0, ovl1_en = 0, ovl2_en = 0, cursor_en = 0;
    logic reg_we = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic busy, done, ber_evt;
    logic [2:0] ber_ch;
    logic [NCH-1:0][31:0] ch_src, ch_id, ch_cmd;
    logic [NCH-1:0][20:0] ch_len;
    logic [NCH-1:0] ch_eof_irq, ch_sof_irq, ch_pal, bs_evt;

    always #4 clk = ~clk;

    fdesc_fetcher u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .main_en(main_en),
        .dual_scan(dual_scan), .ovl1_en(ovl1_en), .ovl2_en(ovl2_en), .cursor_en(cursor_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .ch_src(ch_src), .ch_id(ch_id), .ch_cmd(ch_cmd),
        .ch_len(ch_len), .ch_eof_irq(ch_eof_irq), .ch_sof_irq(ch_sof_irq), .ch_pal(ch_pal),
        .bs_evt(bs_evt), .ber_evt(ber_evt), .ber_ch(ber_ch)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // descriptor contents, computed from the address
    function automatic logic [31:0] src_of(input logic [31:0] b);
        if (b == 32'h1000_0F00) return 32'h0;
        if (b == 32'h1000_0E00) return 32'h3000_0000;
        return 32'h1000_0004 + {20'h0, b[11:0]};
    endfunction
    function automatic logic [31:0] cmd_of(input logic [31:0] b);
        logic [31:0] v;
        v = 32'hF800_0003;
        v[26] = b[4]; v[22] = b[5]; v[21] = b[6]; v[13:2] = b[15:4];
        return v;
    endfunction
    function automatic logic [31:0] mword(input logic [31:0] a);
        logic [31:0] b;
        b = {a[31:4], 4'h0};
        case (a[3:2])
            2'd0: return b + 32'h40;
            2'd1: return src_of(b);
            2'd2: return b ^ 32'hA5A5_0000;
            default: return cmd_of(b);
        endcase
    endfunction
    function automatic bit fits(input logic [31:0] a, input int span);
        logic [32:0] lo, hi;
        lo = {1'b0, a}; hi = {1'b0, a} + 33'(span);
        return ((lo >= W0B) && (hi <= W0B + W0S)) || ((lo >= W1B) && (hi <= W1B + W1S));
    endfunction

    // memory responder and fetch log
    logic [31:0] a_log[64];
    int log_n = 0;
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_rdata <= mword(mem_addr);
            if (log_n < 64) a_log[log_n] = mem_addr;
            log_n++;
        end else mem_ack <= 1'b0;
    end

    // event monitor, sampled after the edge settles
    logic [NCH-1:0] bs_seen = '0, ber_seen = '0;
    int done_n = 0;
    always @(posedge clk) begin
        #2;
        bs_seen = bs_seen | bs_evt;
        if (ber_evt) ber_seen[ber_ch] = 1'b1;
        if (done) done_n++;
    end

    // expected state
    logic [31:0] e_ptr[NCH], e_br[NCH], e_src[NCH], e_id[NCH], e_cmd[NCH], e_log[64];
    logic [20:0] e_len[NCH];
    logic [2:0]  e_fl[NCH];
    logic [NCH-1:0] e_bs, e_ber;
    int e_n;

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask
    task automatic set_ptr(input int c, input logic [31:0] v);
        wr(12'(32'h200 + 16 * c), v); e_ptr[c] = {v[31:4], 4'h0};
    endtask
    task automatic set_br(input int c, input logic [31:0] v);
        wr(12'(32'h100 + 4 * c), v); e_br[c] = v & 32'hFFFF_FFF3;
    endtask
    task automatic set_en(input bit m, input bit d, input bit o1, input bit o2, input bit cu);
        @(negedge clk); main_en = m; dual_scan = d; ovl1_en = o1; ovl2_en = o2; cursor_en = cu;
    endtask
    function automatic bit en_of(input int c);
        if (c == 0) return main_en;
        if (c == 1) return ovl1_en | dual_scan;
        if (c <= 4) return ovl2_en;
        if (c == 5) return cursor_en;
        return 1'b0;
    endfunction

    task automatic predict();
        logic [31:0] a;
        e_bs = '0; e_ber = '0; e_n = 0;
        for (int c = 0; c < NCH; c++) begin
            e_src[c] = '0;
            if (en_of(c)) begin
                if (e_br[c][0]) begin
                    a = {e_br[c][31:4], 4'h0};
                    if (e_br[c][1]) e_bs[c] = 1'b1;
                    e_br[c][0] = 1'b0;
                end else a = e_ptr[c];
                if (fits(a, 16)) begin
                    for (int k = 0; k < 4; k++) begin e_log[e_n] = a + 32'(4 * k); e_n++; end
                    e_ptr[c] = a + 32'h40;
                    e_src[c] = src_of(a);
                    e_id[c]  = a ^ 32'hA5A5_0000;
                    e_cmd[c] = cmd_of(a);
                    e_len[c] = {7'h0, a[15:4], 2'b00};
                    e_fl[c]  = {a[4], a[5], a[6]};
                end
                if ((e_src[c] == '0) || !fits(e_src[c], 1)) e_ber[c] = 1'b1;
            end
        end
    endtask

    task automatic run_frame(input bit defer, input bit extra);
        @(negedge clk); bs_seen = '0; ber_seen = '0; log_n = 0; done_n = 0;
        frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        if (defer) begin
            while (!mem_req) @(negedge clk);
            wr(12'h200, 32'h1000_0700);
        end
        if (extra) begin
            @(negedge clk); frame_start = 1'b1;
            @(negedge clk); frame_start = 1'b0;
        end
        while (done_n == 0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic compare();
        logic [31:0] v;
        int bad;
        for (int c = 0; c < NCH; c++) begin
            chk(ch_src[c] == e_src[c], $sformatf("R2 R3 src ch%0d", c), ch_src[c], e_src[c]);
            chk(ch_id[c] == e_id[c], $sformatf("R2 id ch%0d", c), ch_id[c], e_id[c]);
            chk(ch_cmd[c] == e_cmd[c], $sformatf("R2 cmd ch%0d", c), ch_cmd[c], e_cmd[c]);
            chk(ch_len[c] == e_len[c], $sformatf("R9 len ch%0d", c), 32'(ch_len[c]), 32'(e_len[c]));
            chk({ch_pal[c], ch_sof_irq[c], ch_eof_irq[c]} == e_fl[c], $sformatf("R9 flags ch%0d", c),
                32'({ch_pal[c], ch_sof_irq[c], ch_eof_irq[c]}), 32'(e_fl[c]));
            rd(12'(32'h200 + 16 * c), v);
            chk(v == e_ptr[c], $sformatf("R6 R12 next ptr ch%0d", c), v, e_ptr[c]);
            rd(12'(32'h100 + 4 * c), v);
            chk(v == e_br[c], $sformatf("R5 branch reg ch%0d", c), v, e_br[c]);
        end
        chk(bs_seen == e_bs, "R5 branch events", 32'(bs_seen), 32'(e_bs));
        chk(ber_seen == e_ber, "R8 bus errors", 32'(ber_seen), 32'(e_ber));
        chk(log_n == e_n, "R2 R7 fetch count", 32'(log_n), 32'(e_n));
        bad = 0;
        for (int i = 0; i < e_n && i < log_n; i++) if (a_log[i] != e_log[i]) bad++;
        chk(bad == 0, "R2 fetch order", 32'(bad), 32'h0);
        chk(done_n == 1, "R1 one done per pass", 32'(done_n), 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) begin
            e_ptr[c] = '0; e_br[c] = '0; e_src[c] = '0; e_id[c] = '0; e_cmd[c] = '0;
            e_len[c] = '0; e_fl[c] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        @(negedge clk);
        chk(busy == 1'b0, "R13 busy", 32'(busy), 32'h0);
        chk(ch_src == '0 && ch_cmd == '0, "R13 outputs", ch_src[0], 32'h0);
        rd(12'h200, v); chk(v == 32'h0, "R13 next ptr", v, 32'h0);
        rd(12'h100, v); chk(v == 32'h0, "R13 branch", v, 32'h0);
        // R10 register map
        set_ptr(0, 32'h1000_0105);
        rd(12'h200, v); chk(v == 32'h1000_0100, "R10 ptr low bits", v, 32'h1000_0100);
        wr(12'h204, 32'hDEAD_BEEF); wr(12'h208, 32'h1234_5678); wr(12'h20C, 32'hFFFF_FFFF);
        rd(12'h204, v); chk(v == 32'h0, "R10 src read-only", v, 32'h0);
        rd(12'h208, v); chk(v == 32'h0, "R10 id read-only", v, 32'h0);
        rd(12'h20C, v); chk(v == 32'h0, "R10 cmd read-only", v, 32'h0);
        rd(12'h300, v); chk(v == 32'h0, "R10 unmapped", v, 32'h0);
        rd(12'h270, v); chk(v == 32'h0, "R10 absent channel", v, 32'h0);
        rd(12'h202, v); chk(v == 32'h0, "R10 unaligned", v, 32'h0);
        // R11 branch write mask
        set_br(1, 32'hFFFF_FFFF);
        rd(12'h104, v); chk(v == 32'hFFFF_FFF3, "R11 branch mask", v, 32'hFFFF_FFF3);
        set_br(1, 32'h0);
        for (int c = 0; c < NCH; c++) set_ptr(c, 32'h1000_0100 + 32'(c * 32'h110));
        // main only (R4)
        set_en(1, 0, 0, 0, 0); predict(); run_frame(0, 0); compare();
        // all sources (R2, R4)
        set_en(1, 0, 1, 1, 1); predict(); run_frame(0, 0); compare();
        // dual scan drives channel 1, others cleared (R3, R4)
        set_en(1, 1, 0, 0, 0); predict(); run_frame(0, 0); compare();
        // branches with and without notify (R5)
        set_en(1, 0, 1, 1, 1);
        set_br(2, 32'h1000_0303); set_br(3, 32'h1000_0381);
        predict(); run_frame(0, 0); compare();
        predict(); run_frame(0, 0); compare();
        // window edges and bad sources (R7, R8)
        set_ptr(0, 32'h2000_00F0); set_ptr(1, 32'h2000_0100); set_ptr(2, 32'h1000_0F00);
        set_ptr(3, 32'h1000_0E00); set_ptr(4, 32'h1000_0FF0); set_ptr(5, 32'h0FFF_FFF0);
        predict(); run_frame(0, 0); compare();
        predict(); run_frame(0, 0); compare();
        // deferred pointer write and start while busy (R12, R1)
        set_en(1, 0, 0, 0, 0); set_ptr(0, 32'h1000_0100);
        predict(); run_frame(1, 1); e_ptr[0] = 32'h1000_0700; compare();
        chk(busy == 1'b0, "R1 idle after pass", 32'(busy), 32'h0);
        predict(); run_frame(0, 0); compare();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule